// File: doc/BRIEF.md
# Serial Controller Host Register Sequencer

This block sits between a processor bus and the serial engines of a programmable synchronous/asynchronous serial controller. The processor talks to it over an 8-bit bus with an active-low chip select, active-low read and write strobes, and a select line. The select line decides whether a transfer is a control/status access or a data access. After any reset the meaning of a control write depends on where the block is in a fixed setup sequence. It expects a format (mode) word first. Then, if the format calls for internal character synchronisation, it expects one or two sync characters. Every later control write is a command.

From the format word the block derives the operating parameters that the shift engines use: synchronous or asynchronous operation, bits per character, parity, clocks per bit, stop-bit length in clocks and the break-detect length in clocks. From command words it drives the modem-control outputs and the enable bits, and it issues one-cycle pulses for hunt entry and engine reset. It also keeps the status byte. It holds one transmit character for the transmit engine and one received character from the receive engine, each exchanged through simple strobes.

Top module: `usart_host_regs`

## Requirements
- R1: A write edge (first cycle with `cs_n` and `wr_n` both low) with `sel_ctl`=1 is a control write and with `sel_ctl`=0 is a transmit-character write. A read with `sel_ctl`=1 returns the status byte and with `sel_ctl`=0 returns the held received character.
- R2: The first control write after reset is the format word. Format bits [1:0]=00 select synchronous operation with 1 clock per bit. Values 01, 10 and 11 select asynchronous operation at 1, 16 or 64 clocks per bit (`cfg_clks_per_bit`).
- R3: Format bits [3:2] give 5 to 8 bits per character (`cfg_char_bits` = 5 + field). Bit 4 enables parity. Bit 5 selects even (1) or odd (0) parity.
- R4: In asynchronous operation format bits [7:6] = 01, 10 and 11 mean 1, 1.5 and 2 stop bits. `cfg_stop_clks` = stop-bit count times clocks per bit, rounded down, so 1.5 stops at 16x gives 24. `cfg_brk_clks` = 2 x ((1 + char bits + parity bit) x clocks per bit + stop clocks). Both are 0 in synchronous operation.
- R5: In synchronous operation, format bit 6 = 1 selects external sync, and no sync characters are expected. With bit 6 = 0, the next control write is sync character 1. If bit 7 = 0, the write after that is sync character 2. Each is stored masked to the character length. Commands are accepted only after this sequence.
- R6: Command bit 0 enables transmit, bit 1 drives `dtr_n` low, bit 2 enables receive, bit 3 requests break and bit 5 drives `rts_n` low. Bit 7 gives a one-cycle `hunt_req` pulse, but only in synchronous operation.
- R7: Command bit 6 is an internal reset. It clears the command state and all status flags, pulses `eng_rst`, and makes the next control write a format word again.
- R8: Status bits: 0 transmit-ready flag, 1 receive-ready, 2 `eng_tx_empty`, 3 parity error, 4 overrun, 5 framing error, 6 sync/break detect, 7 inverse of `dsr_n`. After reset the status reads 0x05 with `dsr_n`=1 and `eng_tx_empty`=1.
- R9: `txrdy` is high only when the transmit-ready flag is set, `cts_n` is low and transmit is enabled. A transmit write while enabled clears the flag, latches the character and records whether `cts_n` was low. A transmit write while disabled is ignored. `eng_tx_take` sets the flag again.
- R10: With receive enabled, `eng_rx_stb` stores `eng_rx_char` and sets receive-ready. A strobe while receive-ready is already set also sets overrun. The end of a data read clears receive-ready. With receive disabled the strobe is ignored.
- R11: `eng_rx_par_err` and `eng_rx_frm_err` with an accepted strobe set the parity and framing flags. Command bit 4 clears all three error flags.
- R12: In synchronous operation status bit 6 is set by `eng_rx_sync_hit` and cleared at the end of a status read. In asynchronous operation it follows `eng_rx_break`.
- R13: `dout_oe` is high only while `cs_n` and `rd_n` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| sel_ctl | input | 1 | 1: control/status, 0: data |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Read data to the bus |
| dout_oe | output | 1 | Bus driver enable |
| cts_n | input | 1 | Clear to send, active low |
| dsr_n | input | 1 | Data set ready, active low |
| dtr_n | output | 1 | Data terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| txrdy | output | 1 | Gated transmit-ready output |
| rxrdy | output | 1 | Receive character waiting |
| eng_tx_char | output | 8 | Held transmit character |
| eng_tx_full | output | 1 | Transmit holding register full |
| eng_tx_cts_seen | output | 1 | `cts_n` was low at the last transmit write |
| eng_tx_take | input | 1 | Engine took the held character |
| eng_tx_empty | input | 1 | Engine shift register empty |
| eng_rx_char | input | 8 | Character from the receive engine |
| eng_rx_stb | input | 1 | Received character valid |
| eng_rx_par_err | input | 1 | Parity error with the strobe |
| eng_rx_frm_err | input | 1 | Framing error with the strobe |
| eng_rx_sync_hit | input | 1 | Sync achieved or sync character seen |
| eng_rx_break | input | 1 | Break level from the receive engine |
| cfg_sync | output | 1 | Synchronous operation |
| cfg_ext_sync | output | 1 | External sync selected |
| cfg_single_sync | output | 1 | Single sync character |
| cfg_char_bits | output | 4 | Bits per character |
| cfg_par_en | output | 1 | Parity enabled |
| cfg_par_even | output | 1 | Even parity |
| cfg_clks_per_bit | output | 7 | Clocks per bit |
| cfg_stop_clks | output | 8 | Stop length in clocks |
| cfg_brk_clks | output | 12 | Break-detect length in clocks |
| cfg_sync1 | output | 8 | Sync character 1 |
| cfg_sync2 | output | 8 | Sync character 2 |
| tx_en | output | 1 | Transmit enabled |
| rx_en | output | 1 | Receive enabled |
| send_break | output | 1 | Force break on transmit line |
| hunt_req | output | 1 | One-cycle hunt request |
| eng_rst | output | 1 | One-cycle engine reset |

## Verification
Properties next to the logic check on every cycle that an asynchronous format word leads straight to command state, that an internal-reset command returns to the format stage with commands cleared, that an enabled transmit write empties the ready flag, that a second receive strobe flags overrun, and that a data-read end or error reset clears the right flags. Only the bench's scenarios can show the derived timing parameters for random format words, the masking and ordering of sync characters, the gating of the transmit-ready output by the clear-to-send input and the enable bit, the difference between hunt requests in the two operating modes, and the status byte layout seen through real bus reads.

// File: rtl/usart_host_pkg.sv
package usart_host_pkg;

    localparam int DATA_W = 8;
    localparam int CPB_W  = 7;
    localparam int STOP_W = 8;
    localparam int BRK_W  = 12;
    localparam int BITS_W = 4;

    typedef enum logic [1:0] {
        SEQ_FORMAT = 2'd0,
        SEQ_SYNC_A = 2'd1,
        SEQ_SYNC_B = 2'd2,
        SEQ_CMD    = 2'd3
    } seq_state_e;

    // format word; in synchronous operation stop[1] = single sync, stop[0] = external sync
    typedef struct packed {
        logic [1:0] stop;
        logic       par_even;
        logic       par_en;
        logic [1:0] len;
        logic [1:0] rate;
    } fmt_t;

    typedef struct packed {
        logic hunt;
        logic irst;
        logic rts;
        logic err_clr;
        logic brk;
        logic rx_en;
        logic dtr;
        logic tx_en;
    } cmd_t;

    typedef struct packed {
        logic dsr;
        logic syn_brk;
        logic frm;
        logic ovr;
        logic par;
        logic tx_empty;
        logic rx_rdy;
        logic tx_rdy;
    } stat_t;

    function automatic logic is_sync(fmt_t f);
        return f.rate == 2'b00;
    endfunction

    function automatic logic [CPB_W-1:0] clks_per_bit(fmt_t f);
        case (f.rate)
            2'b10:   return CPB_W'(16);
            2'b11:   return CPB_W'(64);
            default: return CPB_W'(1);
        endcase
    endfunction

    function automatic logic [BITS_W-1:0] char_bits(fmt_t f);
        return BITS_W'(5) + BITS_W'(f.len);
    endfunction

    function automatic logic [STOP_W-1:0] stop_clks(fmt_t f);
        int unsigned halves;
        if (is_sync(f)) return '0;
        case (f.stop)
            2'b01:   halves = 2;
            2'b10:   halves = 3;
            2'b11:   halves = 4;
            default: halves = 0;
        endcase
        return STOP_W'((halves * int'(clks_per_bit(f))) / 2);
    endfunction

    function automatic logic [BRK_W-1:0] brk_clks(fmt_t f);
        int unsigned frame;
        if (is_sync(f)) return '0;
        frame = (1 + int'(char_bits(f)) + int'(f.par_en)) * int'(clks_per_bit(f))
              + int'(stop_clks(f));
        return BRK_W'(2 * frame);
    endfunction

    function automatic logic [DATA_W-1:0] char_mask(fmt_t f);
        return {DATA_W{1'b1}} >> (DATA_W - int'(char_bits(f)));
    endfunction

endpackage

// File: rtl/usart_fmt_decode.sv
module usart_fmt_decode
    import usart_host_pkg::*;
(
    input  fmt_t              fmt,
    output logic              sync_mode,
    output logic              ext_sync,
    output logic              single_sync,
    output logic [BITS_W-1:0] bits,
    output logic              par_en,
    output logic              par_even,
    output logic [CPB_W-1:0]  cpb,
    output logic [STOP_W-1:0] stop_n,
    output logic [BRK_W-1:0]  brk_n,
    output logic [DATA_W-1:0] mask
);
    always_comb begin
        sync_mode   = is_sync(fmt);
        ext_sync    = sync_mode & fmt.stop[0];
        single_sync = sync_mode & fmt.stop[1];
        bits        = char_bits(fmt);
        par_en      = fmt.par_en;
        par_even    = fmt.par_even;
        cpb         = clks_per_bit(fmt);
        stop_n      = stop_clks(fmt);
        brk_n       = brk_clks(fmt);
        mask        = char_mask(fmt);
    end
endmodule

// File: rtl/usart_ctl_seq.sv
module usart_ctl_seq
    import usart_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] mask,
    output fmt_t              fmt_q,
    output cmd_t              cmd_q,
    output logic [DATA_W-1:0] sync_a_q,
    output logic [DATA_W-1:0] sync_b_q,
    output logic              err_clr,
    output logic              soft_rst,
    output logic              hunt_q,
    output logic              eng_rst_q
);
    seq_state_e state_q;
    fmt_t       fmt_in;
    cmd_t       cmd_in;
    logic       in_cmd;

    assign fmt_in   = fmt_t'(din);
    assign cmd_in   = cmd_t'(din);
    assign in_cmd   = ctl_wr && (state_q == SEQ_CMD);
    assign soft_rst = in_cmd && cmd_in.irst;
    assign err_clr  = in_cmd && cmd_in.err_clr && !cmd_in.irst;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SEQ_FORMAT;
            fmt_q    <= '0;
            cmd_q    <= '0;
            sync_a_q <= '0;
            sync_b_q <= '0;
        end else if (ctl_wr) begin
            unique case (state_q)
                SEQ_FORMAT: begin
                    fmt_q   <= fmt_in;
                    state_q <= (is_sync(fmt_in) && !fmt_in.stop[0]) ? SEQ_SYNC_A : SEQ_CMD;
                end
                SEQ_SYNC_A: begin
                    sync_a_q <= din & mask;
                    state_q  <= fmt_q.stop[1] ? SEQ_CMD : SEQ_SYNC_B;
                end
                SEQ_SYNC_B: begin
                    sync_b_q <= din & mask;
                    state_q  <= SEQ_CMD;
                end
                SEQ_CMD: begin
                    if (cmd_in.irst) begin
                        state_q <= SEQ_FORMAT;
                        cmd_q   <= '0;
                    end else begin
                        cmd_q         <= cmd_in;
                        cmd_q.err_clr <= 1'b0;
                        cmd_q.hunt    <= 1'b0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hunt_q    <= 1'b0;
            eng_rst_q <= 1'b1;
        end else begin
            hunt_q    <= in_cmd && cmd_in.hunt && !cmd_in.irst && is_sync(fmt_q);
            eng_rst_q <= soft_rst;
        end
    end

    // R2: an asynchronous format word moves straight to command state
    p_async_fmt_to_cmd_r2: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && state_q == SEQ_FORMAT && din[1:0] != 2'b00) |=> (state_q == SEQ_CMD));

    // R7: internal reset returns to the format stage with commands cleared
    p_irst_to_format_r7: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && state_q == SEQ_CMD && din[6]) |=> (state_q == SEQ_FORMAT && cmd_q == '0));

    // R5: a sync stage is never entered from command state
    p_no_sync_after_cmd_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_CMD && !(ctl_wr && din[6])) |=> (state_q == SEQ_CMD));
endmodule

// File: rtl/usart_stat_regs.sv
module usart_stat_regs
    import usart_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] din,
    input  logic              cts_n,
    input  logic              dsr_n,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              sync_mode,
    input  logic              err_clr,
    input  logic              stat_rd_end,
    input  logic              data_rd_end,
    input  logic              tx_take,
    input  logic              tx_empty,
    input  logic [DATA_W-1:0] rx_char,
    input  logic              rx_stb,
    input  logic              rx_par_err,
    input  logic              rx_frm_err,
    input  logic              sync_hit,
    input  logic              rx_break,
    output stat_t             status,
    output logic [DATA_W-1:0] tx_hold_q,
    output logic              tx_full,
    output logic              tx_cts_q,
    output logic [DATA_W-1:0] rx_hold_q
);
    logic clr;
    logic txrdy_q, rxrdy_q, par_q, ovr_q, frm_q, syn_q;
    logic rx_take;

    assign clr     = rst || soft_rst;
    assign rx_take = rx_stb && rx_en;

    always_ff @(posedge clk) begin
        if (clr) begin
            txrdy_q   <= 1'b1;
            tx_hold_q <= '0;
            tx_cts_q  <= 1'b0;
        end else if (data_wr && tx_en) begin
            txrdy_q   <= 1'b0;
            tx_hold_q <= din;
            tx_cts_q  <= !cts_n;
        end else if (tx_take) begin
            txrdy_q   <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            rxrdy_q   <= 1'b0;
            rx_hold_q <= '0;
            par_q     <= 1'b0;
            ovr_q     <= 1'b0;
            frm_q     <= 1'b0;
            syn_q     <= 1'b0;
        end else begin
            if (err_clr) begin
                par_q <= 1'b0;
                ovr_q <= 1'b0;
                frm_q <= 1'b0;
            end
            if (rx_take) begin
                rxrdy_q   <= 1'b1;
                rx_hold_q <= rx_char;
                if (rxrdy_q)    ovr_q <= 1'b1;
                if (rx_par_err) par_q <= 1'b1;
                if (rx_frm_err) frm_q <= 1'b1;
            end else if (data_rd_end) begin
                rxrdy_q <= 1'b0;
            end
            if (sync_hit)         syn_q <= 1'b1;
            else if (stat_rd_end) syn_q <= 1'b0;
        end
    end

    always_comb begin
        status.tx_rdy   = txrdy_q;
        status.rx_rdy   = rxrdy_q;
        status.tx_empty = tx_empty;
        status.par      = par_q;
        status.ovr      = ovr_q;
        status.frm      = frm_q;
        status.syn_brk  = sync_mode ? syn_q : rx_break;
        status.dsr      = !dsr_n;
    end
    assign tx_full = !txrdy_q;

    // R9: an enabled transmit write leaves the holding register full
    p_txwr_clears_ready_r9: assert property (@(posedge clk) disable iff (rst)
        (data_wr && tx_en && !soft_rst) |=> !txrdy_q);

    // R10: a strobe on an unread character flags overrun
    p_overrun_r10: assert property (@(posedge clk) disable iff (rst)
        (rx_take && rxrdy_q && !soft_rst) |=> ovr_q);

    // R10: end of a data read with no new strobe clears receive-ready
    p_rdend_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (data_rd_end && !rx_take) |=> !rxrdy_q);

    // R11: error reset with no new strobe clears all error flags
    p_errclr_r11: assert property (@(posedge clk) disable iff (rst)
        (err_clr && !rx_take) |=> (!par_q && !ovr_q && !frm_q));
endmodule

// File: rtl/usart_host_regs.sv
module usart_host_regs
    import usart_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              sel_ctl,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    input  logic              cts_n,
    input  logic              dsr_n,
    output logic              dtr_n,
    output logic              rts_n,
    output logic              txrdy,
    output logic              rxrdy,
    output logic [DATA_W-1:0] eng_tx_char,
    output logic              eng_tx_full,
    output logic              eng_tx_cts_seen,
    input  logic              eng_tx_take,
    input  logic              eng_tx_empty,
    input  logic [DATA_W-1:0] eng_rx_char,
    input  logic              eng_rx_stb,
    input  logic              eng_rx_par_err,
    input  logic              eng_rx_frm_err,
    input  logic              eng_rx_sync_hit,
    input  logic              eng_rx_break,
    output logic              cfg_sync,
    output logic              cfg_ext_sync,
    output logic              cfg_single_sync,
    output logic [BITS_W-1:0] cfg_char_bits,
    output logic              cfg_par_en,
    output logic              cfg_par_even,
    output logic [CPB_W-1:0]  cfg_clks_per_bit,
    output logic [STOP_W-1:0] cfg_stop_clks,
    output logic [BRK_W-1:0]  cfg_brk_clks,
    output logic [DATA_W-1:0] cfg_sync1,
    output logic [DATA_W-1:0] cfg_sync2,
    output logic              tx_en,
    output logic              rx_en,
    output logic              send_break,
    output logic              hunt_req,
    output logic              eng_rst
);
    logic wr_act, wr_prev, wr_stb, ctl_wr, data_wr;
    logic rd_act, rd_prev, rd_sel_q, rd_end;
    logic err_clr, soft_rst;
    logic [DATA_W-1:0] mask, rx_hold;
    fmt_t  fmt_q;
    cmd_t  cmd_q;
    stat_t status;

    assign wr_act  = !cs_n && !wr_n;
    assign rd_act  = !cs_n && !rd_n;
    assign wr_stb  = wr_act && !wr_prev;
    assign ctl_wr  = wr_stb && sel_ctl;
    assign data_wr = wr_stb && !sel_ctl;
    assign rd_end  = rd_prev && !rd_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_prev  <= 1'b0;
            rd_prev  <= 1'b0;
            rd_sel_q <= 1'b0;
        end else begin
            wr_prev <= wr_act;
            rd_prev <= rd_act;
            if (rd_act && !rd_prev) rd_sel_q <= sel_ctl;
        end
    end

    usart_fmt_decode u_dec (
        .fmt(fmt_q), .sync_mode(cfg_sync), .ext_sync(cfg_ext_sync),
        .single_sync(cfg_single_sync), .bits(cfg_char_bits), .par_en(cfg_par_en),
        .par_even(cfg_par_even), .cpb(cfg_clks_per_bit), .stop_n(cfg_stop_clks),
        .brk_n(cfg_brk_clks), .mask(mask)
    );

    usart_ctl_seq u_seq (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .din(din), .mask(mask),
        .fmt_q(fmt_q), .cmd_q(cmd_q), .sync_a_q(cfg_sync1), .sync_b_q(cfg_sync2),
        .err_clr(err_clr), .soft_rst(soft_rst), .hunt_q(hunt_req), .eng_rst_q(eng_rst)
    );

    usart_stat_regs u_stat (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .data_wr(data_wr), .din(din),
        .cts_n(cts_n), .dsr_n(dsr_n), .tx_en(cmd_q.tx_en), .rx_en(cmd_q.rx_en),
        .sync_mode(cfg_sync), .err_clr(err_clr),
        .stat_rd_end(rd_end && rd_sel_q), .data_rd_end(rd_end && !rd_sel_q),
        .tx_take(eng_tx_take), .tx_empty(eng_tx_empty), .rx_char(eng_rx_char),
        .rx_stb(eng_rx_stb), .rx_par_err(eng_rx_par_err), .rx_frm_err(eng_rx_frm_err),
        .sync_hit(eng_rx_sync_hit), .rx_break(eng_rx_break), .status(status),
        .tx_hold_q(eng_tx_char), .tx_full(eng_tx_full), .tx_cts_q(eng_tx_cts_seen),
        .rx_hold_q(rx_hold)
    );

    assign dout       = sel_ctl ? DATA_W'(status) : rx_hold;
    assign dout_oe    = rd_act;
    assign dtr_n      = !cmd_q.dtr;
    assign rts_n      = !cmd_q.rts;
    assign tx_en      = cmd_q.tx_en;
    assign rx_en      = cmd_q.rx_en;
    assign send_break = cmd_q.brk;
    assign txrdy      = status.tx_rdy && !cts_n && cmd_q.tx_en;
    assign rxrdy      = status.rx_rdy;

    // R6: hunt pulses appear only in synchronous operation
    p_hunt_sync_only_r6: assert property (@(posedge clk) disable iff (rst)
        hunt_req |-> cfg_sync);
endmodule

// File: tb/sim_usart_host_regs.sv
`timescale 1ns/1ps
module sim_usart_host_regs;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic cs_n = 1, rd_n = 1, wr_n = 1, sel_ctl = 0;
    logic [7:0] din = 0;
    logic [7:0] dout;
    logic dout_oe, cts_n = 1, dsr_n = 1, dtr_n, rts_n, txrdy, rxrdy;
    logic [7:0] eng_tx_char;
    logic eng_tx_full, eng_tx_cts_seen, eng_tx_take = 0, eng_tx_empty = 1;
    logic [7:0] eng_rx_char = 0;
    logic eng_rx_stb = 0, eng_rx_par_err = 0, eng_rx_frm_err = 0;
    logic eng_rx_sync_hit = 0, eng_rx_break = 0;
    logic cfg_sync, cfg_ext_sync, cfg_single_sync, cfg_par_en, cfg_par_even;
    logic [3:0] cfg_char_bits;
    logic [6:0] cfg_clks_per_bit;
    logic [7:0] cfg_stop_clks, cfg_sync1, cfg_sync2;
    logic [11:0] cfg_brk_clks;
    logic tx_en, rx_en, send_break, hunt_req, eng_rst;

    usart_host_regs u0 (.*);

    int n_run = 0, n_fail = 0, hunt_cnt = 0;
    bit done = 0;

    always @(posedge clk) if (!rst && hunt_req) hunt_cnt++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    function automatic int e_cpb(logic [7:0] m);
        if (m[1:0] == 2'b10) return 16;
        if (m[1:0] == 2'b11) return 64;
        return 1;
    endfunction
    function automatic int e_bits(logic [7:0] m);
        return 5 + int'(m[3:2]);
    endfunction
    function automatic int e_stop(logic [7:0] m);
        if (m[1:0] == 0) return 0;
        case (m[7:6])
            2'b01: return e_cpb(m);
            2'b10: return (3 * e_cpb(m)) / 2;
            2'b11: return 2 * e_cpb(m);
            default: return 0;
        endcase
    endfunction
    function automatic int e_brk(logic [7:0] m);
        if (m[1:0] == 0) return 0;
        return 2 * ((1 + e_bits(m) + int'(m[4])) * e_cpb(m) + e_stop(m));
    endfunction
    function automatic logic [7:0] e_mask(logic [7:0] m);
        case (m[3:2])
            2'b00: return 8'h1F;
            2'b01: return 8'h3F;
            2'b10: return 8'h7F;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk) rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
    endtask

    task automatic bus_wr(input logic ctl, input logic [7:0] v);
        @(negedge clk);
        sel_ctl = ctl; din = v; cs_n = 0; wr_n = 0;
        @(negedge clk);
        cs_n = 1; wr_n = 1;
        @(negedge clk);
    endtask

    task automatic bus_rd(input logic ctl, output logic [7:0] v);
        @(negedge clk);
        sel_ctl = ctl; cs_n = 0; rd_n = 0;
        #1 v = dout;
        @(negedge clk);
        cs_n = 1; rd_n = 1;
        @(negedge clk);
    endtask

    task automatic rx_pulse(input logic [7:0] c, input logic pe, input logic fe);
        @(negedge clk);
        eng_rx_char = c; eng_rx_par_err = pe; eng_rx_frm_err = fe; eng_rx_stb = 1;
        @(negedge clk);
        eng_rx_stb = 0; eng_rx_par_err = 0; eng_rx_frm_err = 0;
    endtask

    initial begin
        #(10 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] m, v, s1, s2;
        int h0;
        void'($urandom(32'd2024));
        do_reset();

        // R8 / R1: status after reset, read through control select
        chk_eq("R13 oe idle", dout_oe, 0);
        bus_rd(1, v);
        chk_eq("R8 reset status", v, 8'h05);
        chk_eq("R6 dtr_n reset", dtr_n, 1);

        // R2 R3 R4 R5: random format words and sync sequences
        for (int i = 0; i < 40; i++) begin
            m = 8'($urandom);
            if (m[1:0] != 0 && m[7:6] == 0) m[7:6] = 2'b01;
            do_reset();
            bus_wr(1, m);
            chk_eq("R2 sync flag", cfg_sync, int'(m[1:0] == 0));
            chk_eq("R2 clks per bit", cfg_clks_per_bit, e_cpb(m));
            chk_eq("R3 char bits", cfg_char_bits, e_bits(m));
            chk_eq("R3 parity", {cfg_par_en, cfg_par_even}, {m[4], m[5]});
            chk_eq("R4 stop clks", cfg_stop_clks, e_stop(m));
            chk_eq("R4 break clks", cfg_brk_clks, e_brk(m));
            if (m[1:0] == 0 && !m[6]) begin
                s1 = 8'($urandom);
                bus_wr(1, s1);
                chk_eq("R5 sync1 masked", cfg_sync1, s1 & e_mask(m));
                if (!m[7]) begin
                    s2 = 8'($urandom);
                    bus_wr(1, s2);
                    chk_eq("R5 sync2 masked", cfg_sync2, s2 & e_mask(m));
                end
            end
            chk_eq("R5 no command yet", {dtr_n, rts_n}, 2'b11);
            bus_wr(1, 8'h22);
            chk_eq("R5 command after sequence", {dtr_n, rts_n}, 2'b00);
        end

        // R4: directed 16x, 8 bits, no parity, 1.5 stop
        do_reset();
        bus_wr(1, 8'h8E);
        chk_eq("R4 stop 1.5 at 16x", cfg_stop_clks, 24);
        chk_eq("R4 break 8N1.5 16x", cfg_brk_clks, 336);

        // R6: hunt ignored in asynchronous operation
        h0 = hunt_cnt;
        bus_wr(1, 8'h80);
        chk_eq("R6 no hunt async", hunt_cnt - h0, 0);
        bus_wr(1, 8'h2F);
        chk_eq("R6 command outputs", {tx_en, rx_en, send_break, dtr_n, rts_n}, 5'b11100);
        bus_wr(1, 8'h27);

        // R9: transmit-ready gating and handshake
        cts_n = 1; #1;
        chk_eq("R9 txrdy needs cts", txrdy, 0);
        cts_n = 0; #1;
        chk_eq("R9 txrdy gated on", txrdy, 1);
        bus_wr(0, 8'hA5);
        chk_eq("R9 txrdy after write", txrdy, 0);
        chk_eq("R9 char latched", {eng_tx_full, eng_tx_cts_seen, eng_tx_char}, {2'b11, 8'hA5});
        @(negedge clk) eng_tx_take = 1;
        @(negedge clk) eng_tx_take = 0;
        chk_eq("R9 take sets ready", txrdy, 1);
        bus_wr(1, 8'h26);
        chk_eq("R9 txrdy needs tx_en", txrdy, 0);
        bus_wr(0, 8'h3C);
        bus_rd(1, v);
        chk_eq("R9 disabled write ignored", {v[0], eng_tx_char}, {1'b1, 8'hA5});
        bus_wr(1, 8'h27);

        // R10: receive-ready and overrun
        rx_pulse(8'h5A, 0, 0);
        chk_eq("R10 rxrdy set", rxrdy, 1);
        bus_rd(0, v);
        chk_eq("R1 data read", v, 8'h5A);
        chk_eq("R10 rxrdy cleared", rxrdy, 0);
        rx_pulse(8'h11, 0, 0);
        rx_pulse(8'h22, 1, 1);
        bus_rd(1, v);
        chk_eq("R11 error flags", v[5:3], 3'b111);
        bus_wr(1, 8'h17);
        bus_rd(1, v);
        chk_eq("R11 error reset", v[5:3], 3'b000);
        bus_rd(0, v);
        chk_eq("R10 overwritten char", v, 8'h22);
        bus_wr(1, 8'h01);
        rx_pulse(8'h77, 0, 0);
        chk_eq("R10 disabled rx ignored", rxrdy, 0);

        // R12 async: break follows input; R8 dsr
        eng_rx_break = 1; dsr_n = 0;
        bus_rd(1, v);
        chk_eq("R12 break bit", v[6], 1);
        chk_eq("R8 dsr bit", v[7], 1);
        eng_rx_break = 0; dsr_n = 1;

        // R7: internal reset then a new format word
        bus_wr(1, 8'h40);
        chk_eq("R7 command cleared", {dtr_n, rts_n, tx_en}, 3'b110);
        bus_wr(1, 8'h4F);
        chk_eq("R7 format accepted", cfg_clks_per_bit, 64);
        bus_rd(1, v);
        chk_eq("R7 status cleared", v, 8'h05);

        // R12 sync: latched detect cleared by status read; R6 hunt in sync
        do_reset();
        bus_wr(1, 8'h4C);
        h0 = hunt_cnt;
        bus_wr(1, 8'h84);
        chk_eq("R6 hunt pulse sync", hunt_cnt - h0, 1);
        @(negedge clk) eng_rx_sync_hit = 1;
        @(negedge clk) eng_rx_sync_hit = 0;
        bus_rd(1, v);
        chk_eq("R12 sync detect set", v[6], 1);
        bus_rd(1, v);
        chk_eq("R12 cleared by read", v[6], 0);

        // R13: no drive without chip select
        @(negedge clk) rd_n = 0; #1;
        chk_eq("R13 oe needs cs", dout_oe, 0);
        cs_n = 0; #1;
        chk_eq("R13 oe on read", dout_oe, 1);
        cs_n = 1; rd_n = 1;
        @(negedge clk);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule